// File: doc/BRIEF.md
# Memoization Cache with Write-Snoop Invalidation

This block is a small result cache that sits next to a processor core and is driven by it. The core places the outcome of a computation it repeats often into the cache, for example the measured length of a string, under a key of its choosing, for example the string's start address. Along with the result, the core names the memory window the result was derived from, as a base address and a byte length. On a later lookup the core gets back, one cycle after asking, either a hit with the stored result or a miss.

The block also watches every memory write issued on a snoop port. A write that lands on any byte of an entry's window makes that entry invalid at once. The core can therefore trust any hit without comparing the source data again in software. A single command empties the whole cache.

The store is fully associative. An insert whose key is already present updates that entry in place. A new key goes to the lowest-numbered free entry. When no entry is free, a rotating pointer picks the entry to replace.

Top module: `memo_cache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, and any lookup misses.
- R2: A lookup (`cmd_op` = 2'b01) of a key stored by an insert (`cmd_op` = 2'b00) gives `rsp_valid` = 1, `rsp_hit` = 1 and the stored value on the clock edge after the one that takes the lookup.
- R3: A lookup of a key that no valid entry holds gives `rsp_valid` = 1, `rsp_hit` = 0 and `rsp_value` = 0.
- R4: A snooped write at address A of N bytes (N from 1 to 4) invalidates an entry with window base B and length L exactly when A < B+L and B < A+N, computed without wrap-around. A window of length 0 is never invalidated, and entries whose windows the write misses are not affected.
- R5: When a lookup and a write that invalidates the matching entry occur in the same cycle, the lookup reports a miss.
- R6: An insert whose key matches a valid entry overwrites that entry's value and window and does not take a second entry.
- R7: An insert of a new key while any entry is invalid fills the lowest-indexed invalid entry and does not move the replacement pointer.
- R8: An insert of a new key while all entries are valid replaces the entry at the replacement pointer. The pointer starts at entry 0 after reset, steps by one for each such replacement, and wraps.
- R9: The clear-all command (`cmd_op` = 2'b10) invalidates every entry in one cycle.
- R10: `cmd_op` = 2'b11 changes no entry. `rsp_valid` is 0 in every cycle that does not follow a lookup.
- R11: A snooped write in the same cycle as an insert does not invalidate the entry being written by that insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 insert, 01 lookup, 10 clear all, 11 no operation |
| cmd_key | input | 32 | Key for insert and lookup |
| cmd_value | input | 32 | Result to store on insert |
| cmd_base | input | 32 | Base address of the window the result depends on |
| cmd_len | input | 16 | Byte length of that window |
| snoop_valid | input | 1 | A memory write is observed this cycle |
| snoop_addr | input | 32 | Start byte address of the write |
| snoop_bytes | input | 3 | Bytes written, 1 to 4 |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup found a valid entry |
| rsp_value | output | 32 | Stored result on a hit, 0 on a miss |

## Verification
The hardest condition to reach is the replacement pointer's behaviour when the cache is full. To reach it, the stimulus fills every entry, forces two rotating replacements, and then frees one entry in the middle with a targeted write. The next insert must take the freed entry and leave the pointer where it was, and the insert after that must evict the entry the pointer indicated. The same-cycle races are set up by driving the snoop port and the command port together in one task: a lookup against a write that kills its entry, and an insert against a write on the range being inserted. The edges of the overlap test are probed with writes that end exactly at the window base, start exactly at its end, and touch only its first or last byte.

// File: rtl/memo_pkg.sv
// Shared encodings for the memoization cache.
package memo_pkg;
    typedef enum logic [1:0] {
        OP_INSERT = 2'b00,
        OP_LOOKUP = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_NONE   = 2'b11
    } memo_op_e;
endpackage

// File: rtl/memo_range_check.sv
// Decides whether one snooped write touches one monitored window.
// Assumes the byte count is small and nonzero. The sums are formed one bit
// wider, so a window or write at the top of memory does not wrap.
module memo_range_check #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int BW = 3
) (
    input  logic          en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_bytes,
    input  logic [AW-1:0] rng_base,
    input  logic [LW-1:0] rng_len,
    output logic          touch
);
    localparam int EW = AW + 1;

    logic [EW-1:0] rng_end;
    logic [EW-1:0] wr_end;

    // Half-open interval overlap between write and window.
    always_comb begin
        rng_end = {1'b0, rng_base} + EW'(rng_len);
        wr_end  = {1'b0, wr_addr} + EW'(wr_bytes);
        touch   = en && ({1'b0, wr_addr} < rng_end) && ({1'b0, rng_base} < wr_end);
    end
endmodule

// File: rtl/memo_slot_select.sv
// Chooses the entry an insert writes: the entry with the same key first,
// then the lowest free entry, then the round-robin victim.
// Owns the replacement pointer. It advances only on a victim replacement.
module memo_slot_select #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  key_match,
    input  logic          take,
    output logic [IW-1:0] slot
);
    logic [IW-1:0] rr_q;
    logic          found_key;
    logic          found_free;
    logic          use_victim;

    // Priority selection of the target entry.
    always_comb begin
        slot       = rr_q;
        found_key  = 1'b0;
        found_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found_key && key_match[i]) begin
                slot      = IW'(i);
                found_key = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!found_key && !found_free && !valid[i]) begin
                slot       = IW'(i);
                found_free = 1'b1;
            end
        end
        use_victim = take && !found_key && !found_free;
    end

    // Replacement pointer: step and wrap on each victim replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (use_victim)
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    AST_RR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (&valid) && !(|key_match)) |=> (rr_q != $past(rr_q))); // R8
    AST_RR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(&valid)) |=> (rr_q == $past(rr_q))); // R7
endmodule

// File: rtl/memo_cache.sv
// Processor-controlled memoization cache. It holds N entries of
// {key, value, window base, window length}, looks them up by key with a
// one-cycle response, and drops any entry whose window a snooped write touches.
// Assumes one command per cycle, snoop_bytes in 1..4, and one snooped write
// per cycle.
module memo_cache
    import memo_pkg::*;
#(
    parameter int N  = 8,
    parameter int KW = 32,
    parameter int VW = 32,
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [KW-1:0] cmd_key,
    input  logic [VW-1:0] cmd_value,
    input  logic [AW-1:0] cmd_base,
    input  logic [LW-1:0] cmd_len,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic [BW-1:0] snoop_bytes,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [VW-1:0] rsp_value
);
    localparam int IW = $clog2(N);

    logic [KW-1:0] key_q  [N];
    logic [VW-1:0] val_q  [N];
    logic [AW-1:0] base_q [N];
    logic [LW-1:0] len_q  [N];
    logic [N-1:0]  valid_q;
    logic [N-1:0]  valid_nxt;
    logic [N-1:0]  kill_vec;
    logic [N-1:0]  match_vec;
    logic [IW-1:0] slot;
    logic          do_insert;
    logic          do_lookup;
    logic          do_clear;
    logic          live_hit;
    logic [VW-1:0] live_val;
    logic          dup_keys;

    memo_op_e op;

    // Command decode.
    always_comb begin
        op        = memo_op_e'(cmd_op);
        do_insert = cmd_valid && (op == OP_INSERT);
        do_lookup = cmd_valid && (op == OP_LOOKUP);
        do_clear  = cmd_valid && (op == OP_CLEAR);
    end

    // One overlap checker per entry.
    for (genvar g = 0; g < N; g++) begin : g_snoop
        memo_range_check #(.AW(AW), .LW(LW), .BW(BW)) chk_i (
            .en       (snoop_valid && valid_q[g]),
            .wr_addr  (snoop_addr),
            .wr_bytes (snoop_bytes),
            .rng_base (base_q[g]),
            .rng_len  (len_q[g]),
            .touch    (kill_vec[g])
        );
    end

    // Key comparison against every valid entry.
    always_comb begin
        for (int i = 0; i < N; i++)
            match_vec[i] = valid_q[i] && (key_q[i] == cmd_key);
    end

    memo_slot_select #(.N(N), .IW(IW)) sel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (valid_q),
        .key_match (match_vec),
        .take      (do_insert),
        .slot      (slot)
    );

    // Lookup result: an entry killed this cycle does not count as a hit.
    always_comb begin
        live_hit = |(match_vec & ~kill_vec);
        live_val = '0;
        for (int i = 0; i < N; i++)
            live_val = live_val | (val_q[i] & {VW{match_vec[i] && !kill_vec[i]}});
    end

    // Next valid bits: clear all, else snoop kills, then the insert target.
    always_comb begin
        if (do_clear) begin
            valid_nxt = '0;
        end else begin
            valid_nxt = valid_q & ~kill_vec;
            if (do_insert)
                valid_nxt[slot] = 1'b1;
        end
    end

    // Valid bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else
            valid_q <= valid_nxt;
    end

    // Entry payload written on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                key_q[i]  <= '0;
                val_q[i]  <= '0;
                base_q[i] <= '0;
                len_q[i]  <= '0;
            end
        end else if (do_insert) begin
            key_q[slot]  <= cmd_key;
            val_q[slot]  <= cmd_value;
            base_q[slot] <= cmd_base;
            len_q[slot]  <= cmd_len;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_value <= '0;
        end else begin
            rsp_valid <= do_lookup;
            rsp_hit   <= do_lookup && live_hit;
            rsp_value <= (do_lookup && live_hit) ? live_val : '0;
        end
    end

    // Duplicate-key detector for the checks below.
    always_comb begin
        dup_keys = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (valid_q[i] && valid_q[j] && key_q[i] == key_q[j])
                    dup_keys = 1'b1;
    end

    AST_RSP_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        do_lookup |=> rsp_valid); // R2
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !do_lookup |=> !rsp_valid); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_value == '0)); // R3
    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && !do_insert && !do_clear) |=> ((valid_q & $past(kill_vec)) == '0)); // R4
    AST_RACE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_lookup && ((match_vec & kill_vec) == match_vec)) |=> !rsp_hit); // R5
    AST_KEYS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_keys); // R6
    AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        do_insert |=> (valid_q[$past(slot)] && key_q[$past(slot)] == $past(cmd_key))); // R11
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> (valid_q == '0)); // R9
    AST_SNOOP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |-> (snoop_bytes != '0 && snoop_bytes <= 3'd4)); // R4
endmodule

// File: tb/memo_cache_tb.sv
`timescale 1ns/1ps
module memo_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b11;
    logic [31:0] cmd_key = '0;
    logic [31:0] cmd_value = '0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_len = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic [2:0]  snoop_bytes = 3'd1;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_value;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    memo_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_key(cmd_key),
        .cmd_value(cmd_value), .cmd_base(cmd_base), .cmd_len(cmd_len),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_bytes(snoop_bytes),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_value(rsp_value)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid   = 1'b0;
        cmd_op      = 2'b11;
        snoop_valid = 1'b0;
    endtask

    task automatic do_insert(input logic [31:0] k, input logic [31:0] v,
                             input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00;
        cmd_key = k; cmd_value = v; cmd_base = b; cmd_len = l;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_snoop(input logic [31:0] a, input logic [2:0] n);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a; snoop_bytes = n;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_clear();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic expect_lookup(input logic [31:0] k, input bit hit,
                                 input logic [31:0] v, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_key = k;
        @(negedge clk);
        idle_inputs();
        check(rsp_valid == 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(rsp_hit == hit, {req, " rsp_hit"}, 32'(rsp_hit), 32'(hit));
        check(rsp_value == (hit ? v : 32'd0), {req, " rsp_value"}, rsp_value, hit ? v : 32'd0);
    endtask

    // R1: reset state
    task automatic t_reset();
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        expect_lookup(32'h0, 1'b0, 32'h0, "R1 lookup after reset");
        expect_lookup(32'h1234, 1'b0, 32'h0, "R1 lookup after reset");
    endtask

    // R2, R3: basic hit and miss
    task automatic t_basic();
        do_insert(32'hA000_0000, 32'd17, 32'h1000, 16'd16);
        expect_lookup(32'hA000_0000, 1'b1, 32'd17, "R2 hit");
        expect_lookup(32'hA000_0004, 1'b0, 32'd0, "R3 absent key");
    endtask

    // R4: overlap edges on window 0x1000..0x100F
    task automatic t_overlap();
        do_snoop(32'h0FFC, 3'd4);
        expect_lookup(32'hA000_0000, 1'b1, 32'd17, "R4 write ending at base");
        do_snoop(32'h1010, 3'd1);
        expect_lookup(32'hA000_0000, 1'b1, 32'd17, "R4 write at window end");
        do_snoop(32'h100F, 3'd1);
        expect_lookup(32'hA000_0000, 1'b0, 32'd0, "R4 last byte kills");
        do_insert(32'hA000_0000, 32'd18, 32'h1000, 16'd16);
        do_insert(32'hB000_0000, 32'd5, 32'h5000, 16'd8);
        do_snoop(32'h0FFD, 3'd4);
        expect_lookup(32'hA000_0000, 1'b0, 32'd0, "R4 first byte kills");
        expect_lookup(32'hB000_0000, 1'b1, 32'd5, "R4 other entry kept");
        do_insert(32'hC000_0000, 32'd9, 32'h2000, 16'd0);
        do_snoop(32'h2000, 3'd4);
        expect_lookup(32'hC000_0000, 1'b1, 32'd9, "R4 zero length kept");
        do_insert(32'hD000_0000, 32'd3, 32'hFFFF_FFFC, 16'd8);
        do_snoop(32'h0000_0000, 3'd4);
        expect_lookup(32'hD000_0000, 1'b1, 32'd3, "R4 no wrap at top");
    endtask

    // R5: same-cycle lookup and killing write
    task automatic t_race_lookup();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_key = 32'hB000_0000;
        snoop_valid = 1'b1; snoop_addr = 32'h5004; snoop_bytes = 3'd2;
        @(negedge clk);
        idle_inputs();
        check(rsp_valid && !rsp_hit, "R5 race lookup misses", 32'(rsp_hit), 32'd0);
        check(rsp_value == 32'd0, "R5 race value", rsp_value, 32'd0);
        expect_lookup(32'hB000_0000, 1'b0, 32'd0, "R5 entry gone");
    endtask

    // R11: same-cycle insert and write on its range
    task automatic t_race_insert();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_key = 32'hE000_0000;
        cmd_value = 32'd44; cmd_base = 32'h6000; cmd_len = 16'd4;
        snoop_valid = 1'b1; snoop_addr = 32'h6000; snoop_bytes = 3'd4;
        @(negedge clk);
        idle_inputs();
        expect_lookup(32'hE000_0000, 1'b1, 32'd44, "R11 insert survives write");
    endtask

    // R6: overwrite in place takes the new window
    task automatic t_overwrite();
        do_insert(32'hF000_0000, 32'd1, 32'h7000, 16'd4);
        do_insert(32'hF000_0000, 32'd2, 32'h8000, 16'd4);
        expect_lookup(32'hF000_0000, 1'b1, 32'd2, "R6 new value");
        do_snoop(32'h7000, 3'd4);
        expect_lookup(32'hF000_0000, 1'b1, 32'd2, "R6 old window dropped");
        do_snoop(32'h8002, 3'd1);
        expect_lookup(32'hF000_0000, 1'b0, 32'd0, "R6 new window monitored");
    endtask

    // R10: no-op command
    task automatic t_noop();
        do_insert(32'h1111_0000, 32'd77, 32'h9100, 16'd4);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_key = 32'h1111_0000;
        @(negedge clk);
        idle_inputs();
        check(rsp_valid == 1'b0, "R10 no response to no-op", 32'(rsp_valid), 32'd0);
        expect_lookup(32'h1111_0000, 1'b1, 32'd77, "R10 entry unchanged");
    endtask

    // R9: clear all
    task automatic t_clear();
        do_clear();
        expect_lookup(32'h1111_0000, 1'b0, 32'd0, "R9 cleared");
        expect_lookup(32'hE000_0000, 1'b0, 32'd0, "R9 cleared");
        expect_lookup(32'hD000_0000, 1'b0, 32'd0, "R9 cleared");
    endtask

    // R7, R8: fill, rotate, free a middle entry
    task automatic t_replace();
        for (int i = 0; i < 8; i++)
            do_insert(32'h100 + i, 32'd1000 + i, 32'h9000_0000 + i * 32'h100, 16'd4);
        for (int i = 0; i < 8; i++)
            expect_lookup(32'h100 + i, 1'b1, 32'd1000 + i, "R7 fill");
        do_insert(32'h200, 32'd2000, 32'hA100_0000, 16'd4);
        expect_lookup(32'h100, 1'b0, 32'd0, "R8 victim entry 0");
        expect_lookup(32'h200, 1'b1, 32'd2000, "R8 new key");
        expect_lookup(32'h101, 1'b1, 32'd1001, "R8 neighbour kept");
        do_insert(32'h201, 32'd2001, 32'hA100_0100, 16'd4);
        expect_lookup(32'h101, 1'b0, 32'd0, "R8 victim entry 1");
        do_snoop(32'h9000_0300, 3'd1);
        do_insert(32'h300, 32'd3000, 32'hA200_0000, 16'd4);
        expect_lookup(32'h102, 1'b1, 32'd1002, "R7 free entry used");
        expect_lookup(32'h300, 1'b1, 32'd3000, "R7 new key");
        do_insert(32'h301, 32'd3001, 32'hA200_0100, 16'd4);
        expect_lookup(32'h102, 1'b0, 32'd0, "R8 pointer held at 2");
        expect_lookup(32'h104, 1'b1, 32'd1004, "R8 entry 4 kept");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_overlap();
        t_race_lookup();
        t_race_insert();
        t_overwrite();
        t_noop();
        t_clear();
        t_replace();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule